// File: doc/BRIEF.md
# Warp Instruction Scheduler with Scoreboarded Lane Dispatch

This block issues instructions for a small pool of warps that share one processing partition. Every warp runs the same fixed four-step program: load into R1, load into R2, a floating-point add of R1 and R2 into R3, and a store of R3. Each warp keeps its own program counter and a two-bit scoreboard of loads whose data has not yet returned. When the dispatch stage is free, the scheduler picks one eligible warp. The choice is round-robin, starting after the warp that issued most recently.

The dispatch stage spreads the 32 threads of the chosen warp over the execution lanes. There are 8 load/store lanes, so a load or store takes four consecutive cycles of eight threads each, and no other warp can issue during that time. There are 32 floating-point lanes, so an add goes out in one cycle. Load data returns later, out of band, on a writeback port. The add for a warp stays blocked until both of its loads have written back.

The issue port carries one strobe per cycle with the warp number, the thread-slice index and the opcode. It is meant to feed lane models or a trace monitor. A done flag rises once every warp has retired.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, issueValid and done are low. Warp 0 is picked in that first cycle, and its first slice appears one cycle later.
- R2: A load or store of a warp is issued as four strobes on consecutive cycles. All four carry the same warp and opcode, with issueSlice counting 0, 1, 2, 3. Nothing else issues during them, and no earlier start is possible for another warp.
- R3: The add of a warp is not issued until writebacks for both R1 (wbReg=1) and R2 (wbReg=2) of that warp have arrived. One writeback alone is not enough. A writeback in cycle c makes the warp selectable in cycle c+1, so its add strobe appears in cycle c+2 at the earliest.
- R4: An add is issued as a single strobe with issueSlice 0.
- R5: The cycle after the last strobe of an instruction has no issue. The warp is released and its program counter advances in that cycle. A newly picked warp shows its first strobe one cycle after it is picked.
- R6: In its release cycle a warp cannot be picked. If it is the only eligible warp, its next instruction starts no earlier than two cycles after its last strobe.
- R7: Among the eligible warps, the scheduler picks the first one in ascending order, wrapping around, after the warp that was picked most recently.
- R8: Each warp issues, in this order, load (issueOp=1), load (issueOp=1), add (issueOp=2) and store (issueOp=3). issueOp is 0 when nothing issues.
- R9: done rises in the cycle after the last warp's store releases, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wbValid | input | 1 | A load writeback is present this cycle |
| wbWarp | input | WID_W | Warp the writeback belongs to |
| wbReg | input | 2 | Register written back: 1 for R1, 2 for R2 |
| issueValid | output | 1 | A thread slice is issued this cycle |
| issueWarp | output | WID_W | Warp of the issued slice |
| issueSlice | output | SLICE_W | Thread-slice index within the instruction |
| issueOp | output | 2 | Opcode: 0 none, 1 load, 2 add, 3 store |
| done | output | 1 | All warps have retired |

## Verification
The issue outputs come from registers. A warp picked in cycle c shows slice 0 in cycle c+1. The cycle after its final slice is always empty, and a writeback in cycle c can produce an add strobe no earlier than cycle c+2. The bench numbers cycles from reset release and drives each writeback for a named cycle. It records the outputs on the falling clock edge and compares every recorded cycle against an expected list of instruction start cycles. That list was worked out from these latencies and from round-robin order. The cycles that must stay empty (release cycles, cooling-down warps and blocked adds) are checked as explicitly as the strobes.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LD   = 2'd1,
    OP_FADD = 2'd2,
    OP_ST   = 2'd3
  } opcode_e;

  // strobes from control to the per-warp datapath
  typedef struct packed {
    logic grantStb;    // a warp is picked this cycle
    logic releaseStb;  // the active warp sends its last slice this cycle
  } sched_strb_t;

endpackage

// File: rtl/warp_ctx_dp.sv
module warp_ctx_dp
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 3,
  parameter int WID_W     = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  sched_strb_t                  strb,
  input  logic [WID_W-1:0]             grantWarp,
  input  logic [WID_W-1:0]             relWarp,
  input  logic                         wbValid,
  input  logic [WID_W-1:0]             wbWarp,
  input  logic [1:0]                   wbReg,
  output logic [NUM_WARPS-1:0]         eligMask,
  output logic [NUM_WARPS-1:0][1:0]    warpOp,
  output logic                         allRetired
);

  localparam int PROG_LEN = 4;
  localparam int PC_W     = $clog2(PROG_LEN + 1);

  logic [NUM_WARPS-1:0] retired;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic [PC_W-1:0] pc;
    logic [1:0]      pend;   // bit0: R1 outstanding, bit1: R2 outstanding
    logic            isGrant;
    logic            isRel;
    logic            isWb;
    logic [1:0]      setBits;
    logic [1:0]      clrBits;

    assign isGrant = strb.grantStb && (grantWarp == WID_W'(w));
    assign isRel   = strb.releaseStb && (relWarp == WID_W'(w));
    assign isWb    = wbValid && (wbWarp == WID_W'(w));

    always_comb begin
      setBits = 2'b00;
      if (isGrant && pc == PC_W'(0)) setBits = 2'b01;
      if (isGrant && pc == PC_W'(1)) setBits = 2'b10;
      clrBits = isWb ? wbReg : 2'b00;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pc   <= '0;
        pend <= '0;
      end else begin
        if (isRel) pc <= PC_W'(pc + 1'b1);
        pend <= (pend & ~clrBits) | setBits;
      end
    end

    always_comb begin
      unique case (pc)
        PC_W'(0), PC_W'(1): warpOp[w] = OP_LD;
        PC_W'(2):           warpOp[w] = OP_FADD;
        PC_W'(3):           warpOp[w] = OP_ST;
        default:            warpOp[w] = OP_NONE;
      endcase
    end

    assign eligMask[w] = (pc < PC_W'(PROG_LEN)) && ((pc != PC_W'(2)) || (pend == 2'b00));
    assign retired[w]  = (pc == PC_W'(PROG_LEN));
  end

  assign allRetired = &retired;

endmodule

// File: rtl/warp_rr_ctrl.sv
module warp_rr_ctrl
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 3,
  parameter int WID_W     = 2,
  parameter int SLICE_W   = 2,
  parameter int LS_SLICES = 4,
  parameter int FP_SLICES = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_WARPS-1:0]      eligMask,
  input  logic [NUM_WARPS-1:0][1:0] warpOp,
  output sched_strb_t               strb,
  output logic [WID_W-1:0]          grantWarp,
  output logic [WID_W-1:0]          curWarp,
  output logic                      active,
  output logic [SLICE_W-1:0]        sliceIdx,
  output opcode_e                   curOp
);

  logic                 coolValid;
  logic [WID_W-1:0]     coolWarp;
  logic [WID_W-1:0]     lastWarp;
  logic [NUM_WARPS-1:0] candMask;
  logic                 found;
  logic [WID_W-1:0]     pick;
  logic [SLICE_W-1:0]   lastSlice;

  // round-robin search: scan from the far end so the nearest hit wins
  always_comb begin
    candMask = eligMask;
    if (coolValid) candMask[coolWarp] = 1'b0;
    found = 1'b0;
    pick  = '0;
    for (int k = NUM_WARPS; k >= 1; k--) begin
      if (candMask[(int'(lastWarp) + k) % NUM_WARPS]) begin
        found = 1'b1;
        pick  = WID_W'((int'(lastWarp) + k) % NUM_WARPS);
      end
    end
  end

  assign lastSlice       = (curOp == OP_FADD) ? SLICE_W'(FP_SLICES - 1) : SLICE_W'(LS_SLICES - 1);
  assign strb.grantStb   = !active && found;
  assign strb.releaseStb = active && (sliceIdx == lastSlice);
  assign grantWarp       = pick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      curWarp   <= '0;
      sliceIdx  <= '0;
      curOp     <= OP_NONE;
      lastWarp  <= WID_W'(NUM_WARPS - 1);
      coolValid <= 1'b0;
      coolWarp  <= '0;
    end else begin
      coolValid <= strb.releaseStb;
      if (strb.releaseStb) coolWarp <= curWarp;
      if (strb.grantStb) begin
        active   <= 1'b1;
        curWarp  <= pick;
        sliceIdx <= '0;
        curOp    <= opcode_e'(warpOp[pick]);
        lastWarp <= pick;
      end else if (strb.releaseStb) begin
        active   <= 1'b0;
        sliceIdx <= '0;
        curOp    <= OP_NONE;
      end else if (active) begin
        sliceIdx <= SLICE_W'(sliceIdx + 1'b1);
      end
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS  = 3,
  parameter int WARP_SIZE  = 32,
  parameter int LS_LANES   = 8,
  parameter int FP_LANES   = 32,
  localparam int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int LS_SLICES = WARP_SIZE / LS_LANES,
  localparam int FP_SLICES = WARP_SIZE / FP_LANES,
  localparam int SLICE_W   = (LS_SLICES > 1) ? $clog2(LS_SLICES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wbValid,
  input  logic [WID_W-1:0]   wbWarp,
  input  logic [1:0]         wbReg,
  output logic               issueValid,
  output logic [WID_W-1:0]   issueWarp,
  output logic [SLICE_W-1:0] issueSlice,
  output logic [1:0]         issueOp,
  output logic               done
);

  sched_strb_t               strb;
  logic [NUM_WARPS-1:0]      eligMask;
  logic [NUM_WARPS-1:0][1:0] warpOp;
  logic [WID_W-1:0]          grantWarp;
  logic [WID_W-1:0]          curWarp;
  logic                      active;
  logic [SLICE_W-1:0]        sliceIdx;
  opcode_e                   curOp;

  warp_ctx_dp #(
    .NUM_WARPS(NUM_WARPS),
    .WID_W    (WID_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .grantWarp (grantWarp),
    .relWarp   (curWarp),
    .wbValid   (wbValid),
    .wbWarp    (wbWarp),
    .wbReg     (wbReg),
    .eligMask  (eligMask),
    .warpOp    (warpOp),
    .allRetired(done)
  );

  warp_rr_ctrl #(
    .NUM_WARPS(NUM_WARPS),
    .WID_W    (WID_W),
    .SLICE_W  (SLICE_W),
    .LS_SLICES(LS_SLICES),
    .FP_SLICES(FP_SLICES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .eligMask (eligMask),
    .warpOp   (warpOp),
    .strb     (strb),
    .grantWarp(grantWarp),
    .curWarp  (curWarp),
    .active   (active),
    .sliceIdx (sliceIdx),
    .curOp    (curOp)
  );

  assign issueValid = active;
  assign issueWarp  = curWarp;
  assign issueSlice = sliceIdx;
  assign issueOp    = active ? curOp : OP_NONE;

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int WID_W     = 2,
  parameter int SLICE_W   = 2,
  parameter int LS_SLICES = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               issueValid,
  input logic [WID_W-1:0]   issueWarp,
  input logic [SLICE_W-1:0] issueSlice,
  input logic [1:0]         issueOp,
  input logic               done
);

  logic lastSlc;
  assign lastSlc = issueValid && ((issueOp == 2'd2) || (issueSlice == SLICE_W'(LS_SLICES - 1)));

  // R2: load/store slices run back to back for one warp
  a_r2_slice_run: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueOp != 2'd2 && issueSlice != SLICE_W'(LS_SLICES - 1)) |=>
      (issueValid && issueWarp == $past(issueWarp) && issueOp == $past(issueOp)
       && issueSlice == SLICE_W'($past(issueSlice) + 1'b1)));

  // R4: an add is one slice
  a_r4_fadd_one: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueOp == 2'd2) |-> (issueSlice == '0));

  // R5: release cycle is empty
  a_r5_release_gap: assert property (@(posedge clk) disable iff (!rstN)
    lastSlc |=> !issueValid);

  // R6: a released warp does not start again two cycles later
  a_r6_no_reissue: assert property (@(posedge clk) disable iff (!rstN)
    lastSlc ##2 issueValid |-> (issueWarp != $past(issueWarp, 2)));

  // R8: a valid strobe never carries the idle opcode
  a_r8_op_valid: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (issueOp != 2'd0));

  // R9: done holds once set
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .WID_W    (WID_W),
  .SLICE_W  (SLICE_W),
  .LS_SLICES(LS_SLICES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .issueValid(issueValid),
  .issueWarp (issueWarp),
  .issueSlice(issueSlice),
  .issueOp   (issueOp),
  .done      (done)
);

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wbValid = 1'b0;
  logic [1:0] wbWarp = '0;
  logic [1:0] wbReg = '0;
  logic       issueValid;
  logic [1:0] issueWarp;
  logic [1:0] issueSlice;
  logic [1:0] issueOp;
  logic       done;

  always #2.5 clk = ~clk;

  warp_issue_sched u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .wbValid   (wbValid),
    .wbWarp    (wbWarp),
    .wbReg     (wbReg),
    .issueValid(issueValid),
    .issueWarp (issueWarp),
    .issueSlice(issueSlice),
    .issueOp   (issueOp),
    .done      (done)
  );

  // expected instruction starts: scenario, first-slice cycle, warp, opcode
  localparam int NE = 19;
  localparam int E_SCN [NE] = '{0,0,0,0,0,0,0,0,0,0,0,0, 1,1,1,1,1,1,1};
  localparam int E_CYC [NE] = '{1,6,11,16,21,26,31,34,36,41,43,48, 1,6,11,16,21,26,67};
  localparam int E_WRP [NE] = '{0,1,2,0,1,2,1,0,1,2,0,2, 0,1,2,0,1,2,0};
  localparam int E_OP  [NE] = '{1,1,1,1,1,1,2,2,3,2,3,3, 1,1,1,1,1,1,2};
  // writebacks: scenario, cycle, warp, register code
  localparam int NWB = 8;
  localparam int W_SCN [NWB] = '{0,0,0,0,0,0,1,1};
  localparam int W_CYC [NWB] = '{12,26,31,32,36,37,61,65};
  localparam int W_WRP [NWB] = '{1,1,0,0,2,2,0,0};
  localparam int W_REG [NWB] = '{1,2,1,2,1,2,1,2};

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;
  int  sPack [0:79];
  bit  sDone [0:79];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic runScn(input int scn, input int len);
    @(negedge clk);
    rstN = 1'b0;
    wbValid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      sPack[c] = issueValid ? (1000 + 100 * int'(issueWarp) + 10 * int'(issueSlice) + int'(issueOp))
                            : int'(issueOp);
      sDone[c] = done;
      wbValid = 1'b0;
      for (int k = 0; k < NWB; k++) begin
        if (W_SCN[k] == scn && W_CYC[k] == c) begin
          wbValid = 1'b1;
          wbWarp  = 2'(W_WRP[k]);
          wbReg   = 2'(W_REG[k]);
        end
      end
    end
    wbValid = 1'b0;
    for (int c = 0; c < len; c++) begin
      int eIdx;
      eIdx = -1;
      for (int e = 0; e < NE; e++)
        if (E_SCN[e] == scn && c >= E_CYC[e] && c < E_CYC[e] + ((E_OP[e] == 2) ? 1 : 4)) eIdx = e;
      if (eIdx < 0) begin
        string tag;
        tag = (c == 0) ? "R1" : (scn == 0 && c == 32) ? "R6" : (scn == 1 && c >= 30) ? "R3" : "R5";
        chk(sPack[c] == 0, tag, $sformatf("scn%0d cycle %0d idle", scn, c), sPack[c], 0);
      end else begin
        int exp;
        exp = 1000 + 100 * E_WRP[eIdx] + 10 * (c - E_CYC[eIdx]) + E_OP[eIdx];
        chk(sPack[c] == exp, (E_OP[eIdx] == 2) ? "R4" : "R2",
            $sformatf("scn%0d cycle %0d strobe", scn, c), sPack[c], exp);
        if (c == E_CYC[eIdx]) begin
          chk(sPack[c] / 100 % 10 == E_WRP[eIdx], "R7", $sformatf("scn%0d cycle %0d warp pick", scn, c),
              sPack[c] / 100 % 10, E_WRP[eIdx]);
          chk(sPack[c] % 10 == E_OP[eIdx], "R8", $sformatf("scn%0d cycle %0d program order", scn, c),
              sPack[c] % 10, E_OP[eIdx]);
        end
      end
    end
  endtask

  initial begin
    runScn(0, 56);
    chk(sDone[0] == 1'b0, "R1", "done after reset", int'(sDone[0]), 0);
    chk(sDone[51] == 1'b0, "R9", "done before last release", int'(sDone[51]), 0);
    chk(sDone[52] == 1'b1, "R9", "done after last release", int'(sDone[52]), 1);
    chk(sDone[55] == 1'b1, "R9", "done holds", int'(sDone[55]), 1);
    runScn(1, 70);
    chk(sDone[0] == 1'b0, "R1", "done cleared by reset", int'(sDone[0]), 0);
    chk(sDone[69] == 1'b0, "R9", "done low with warps pending", int'(sDone[69]), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not end actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule